// File: doc/BRIEF.md
# Processor Branch Trace Encoder

This block observes a processor that retires at most one instruction per cycle and turns its control flow into a compact stream of trace packets. Sequential instructions and direct jumps produce nothing. Conditional branches each add one taken/not-taken bit to a branch history word. Addresses go out only at points the program image cannot predict: the start of tracing, indirect jumps and traps. Off-chip software combines the packets with the program image to rebuild the full instruction sequence.

Each retirement presents four values. `retireAddr` is the address of the retiring instruction. `nextAddr` is the address that executes after it: the fall-through, the branch or jump target, or the trap handler. `retireType` classifies the instruction, and `trapCause` gives the cause of a trap. Packets queue in a small internal FIFO and leave as bytes on a valid/ready stream. If the FIFO cannot take a packet, the packet is dropped and an overflow flag is raised. The encoder then re-establishes a known starting point with a fresh sync packet.

Top module: `branchTraceEncoder`

## Requirements
- R1: While `traceEnable` is high, the first retirement after reset, after re-enable or after an overflow produces a sync packet. Its header is 0x24 (type 1 in bits 7:5, length 4 in bits 4:0), and its payload is the full `nextAddr`. That retirement records no branch bit, and `nextAddr` becomes the reference address.
- R2: Retirements of type 0 (sequential) produce no packet.
- R3: Each retirement of type 1 (branch not taken) or type 2 (branch taken) stores one bit in the branch history. The bit is 1 for taken. The first branch after a flush goes in bit 0, the next in bit 1, and so on.
- R4: Retirements of type 3 (direct jump) produce no packet and leave the branch history unchanged.
- R5: A type 4 (indirect jump) emits header 0x69. The payload is: a count byte holding the number of pending branch bits, the 4-byte history word, then the 4-byte two's-complement difference `nextAddr` minus the reference address. The history is then cleared, and `nextAddr` becomes the reference.
- R6: A type 5 (exception) or type 6 (interrupt) emits header 0x8E. The payload is: the count byte, the 4-byte history word, a cause byte (bit 7 set for an interrupt, bits 6:0 from `trapCause`), the full `retireAddr`, then the full `nextAddr`. The history is then cleared, and `nextAddr` becomes the reference.
- R7: The branch that brings the history to 31 bits emits header 0x45, with payload count byte 31 and the 4-byte history word, and the count returns to zero.
- R8: Each packet is sent as its header byte, then its payload bytes least significant byte first. While `outValid` is high and `outReady` is low, `outValid` and `outData` hold.
- R9: The FIFO holds 4 packets, and a packet occupies its slot until its last byte is accepted. A packet that finds the FIFO full is dropped. This sets `overflow` and clears the branch history. `overflow` stays high until the next sync packet is queued.
- R10: While `traceEnable` is low, no packet is produced and the branch history is cleared. The next enabled retirement produces a sync packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEnable | input | 1 | Tracing on |
| retireValid | input | 1 | An instruction retires this cycle |
| retireType | input | 3 | Instruction class, codes 0 to 6 |
| retireAddr | input | 32 | Address of the retiring instruction |
| nextAddr | input | 32 | Address executed next (target or handler) |
| trapCause | input | 7 | Trap cause code |
| outValid | output | 1 | Trace byte available |
| outData | output | 8 | Trace byte |
| outReady | input | 1 | Consumer accepts the byte |
| overflow | output | 1 | A packet was lost; resync pending |

## Verification
Several properties are checked on every cycle:
- the stream holds steady while stalled;
- no packet is written into a full FIFO;
- the branch count never reaches 31 between packets, and each plain branch advances it by one;
- sequential instructions and direct jumps never push;
- an overflow always implies a pending resync.

Other behaviour can only be shown by the bench's scenarios. This covers packet contents, little-endian byte order, negative address deltas, the cause byte for interrupts versus exceptions, the automatic flush at 31 branches, loss and recovery under a stalled consumer, and resync after disable. The bench checks these against a model that computes every expected byte.

// File: rtl/trace_pkg.sv
package trace_pkg;

  localparam logic [2:0] RT_SEQ    = 3'd0;
  localparam logic [2:0] RT_NTAKEN = 3'd1;
  localparam logic [2:0] RT_TAKEN  = 3'd2;
  localparam logic [2:0] RT_DJUMP  = 3'd3;
  localparam logic [2:0] RT_IJUMP  = 3'd4;
  localparam logic [2:0] RT_EXC    = 3'd5;
  localparam logic [2:0] RT_IRQ    = 3'd6;

  localparam logic [2:0] PK_SYNC   = 3'd1;
  localparam logic [2:0] PK_BRANCH = 3'd2;
  localparam logic [2:0] PK_ADDR   = 3'd3;
  localparam logic [2:0] PK_TRAP   = 3'd4;

  typedef struct packed {
    logic syncPush;
    logic mapPush;
    logic addrPush;
    logic trapPush;
    logic bitShift;
    logic bitVal;
    logic mapClear;
  } strobes_t;

endpackage

// File: rtl/traceCtrl.sv
module traceCtrl
  import trace_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       traceEnable,
  input  logic       retireValid,
  input  logic [2:0] retireType,
  input  logic       mapLastSlot,
  input  logic       fifoFull,
  output strobes_t   strb,
  output logic       overflow
);

  logic syncPending;
  logic dSync, dMap, dAddr, dTrap, dBit, anyWant, drop;

  always_comb begin
    dSync = 1'b0;
    dMap  = 1'b0;
    dAddr = 1'b0;
    dTrap = 1'b0;
    dBit  = 1'b0;
    if (traceEnable && retireValid) begin
      if (syncPending) begin
        dSync = 1'b1;
      end else begin
        unique case (retireType)
          RT_NTAKEN, RT_TAKEN: begin
            dBit = 1'b1;
            dMap = mapLastSlot;
          end
          RT_IJUMP:       dAddr = 1'b1;
          RT_EXC, RT_IRQ: dTrap = 1'b1;
          default: ;
        endcase
      end
    end
    anyWant = dSync | dMap | dAddr | dTrap;
    drop    = anyWant & fifoFull;
  end

  always_comb begin
    strb          = '0;
    strb.bitVal   = (retireType == RT_TAKEN);
    if (!traceEnable || drop) begin
      strb.mapClear = 1'b1;
    end else begin
      strb.syncPush = dSync;
      strb.mapPush  = dMap;
      strb.addrPush = dAddr;
      strb.trapPush = dTrap;
      strb.bitShift = dBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPending <= 1'b1;
      overflow    <= 1'b0;
    end else begin
      if (!traceEnable || drop) syncPending <= 1'b1;
      else if (strb.syncPush)   syncPending <= 1'b0;
      if (drop)                 overflow <= 1'b1;
      else if (strb.syncPush)   overflow <= 1'b0;
    end
  end

  // R2
  seq_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (traceEnable && retireValid && !syncPending &&
     (retireType == RT_SEQ || retireType == RT_DJUMP))
    |-> !(strb.syncPush || strb.mapPush || strb.addrPush || strb.trapPush));

  // R9
  ovf_resync_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> syncPending);

endmodule

// File: rtl/traceDatapath.sv
module traceDatapath
  import trace_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAP_W      = 31,
  parameter int CAUSE_W    = 7,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [2:0]         retireType,
  input  logic [ADDR_W-1:0]  retireAddr,
  input  logic [ADDR_W-1:0]  nextAddr,
  input  logic [CAUSE_W-1:0] trapCause,
  output logic               mapLastSlot,
  output logic               fifoFull,
  output logic               outValid,
  output logic [7:0]         outData,
  input  logic               outReady
);

  localparam int ADDR_B   = ADDR_W / 8;
  localparam int MAP_B    = (MAP_W + 7) / 8;
  localparam int CNT_W    = $clog2(MAP_W + 1);
  localparam int PAY_B    = 2 + MAP_B + 2 * ADDR_B;
  localparam int PAY_W    = PAY_B * 8;
  localparam int LEN_SYNC = ADDR_B;
  localparam int LEN_MAP  = 1 + MAP_B;
  localparam int LEN_ADDR = 1 + MAP_B + ADDR_B;
  localparam int LEN_TRAP = PAY_B;
  localparam int PTR_W    = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int OCC_W    = $clog2(FIFO_DEPTH + 1);

  logic [MAP_W-1:0]  mapReg, mapNow, bitMask;
  logic [CNT_W-1:0]  mapCnt, cntNow;
  logic [ADDR_W-1:0] lastAddr, deltaAddr;
  logic [MAP_B*8-1:0] mapBytes;
  logic [7:0]        cntByte, causeByte, hdrIn;
  logic [PAY_W-1:0]  payIn;
  logic              anyPush;

  assign bitMask     = (strb.bitShift && strb.bitVal) ? (MAP_W'(1) << mapCnt) : '0;
  assign mapNow      = mapReg | bitMask;
  assign cntNow      = mapCnt + CNT_W'(strb.bitShift);
  assign mapLastSlot = (mapCnt == CNT_W'(MAP_W - 1));
  assign mapBytes    = (MAP_B*8)'(mapNow);
  assign cntByte     = 8'(cntNow);
  assign causeByte   = 8'({retireType == RT_IRQ, trapCause});
  assign deltaAddr   = nextAddr - lastAddr;
  assign anyPush     = strb.syncPush | strb.mapPush | strb.addrPush | strb.trapPush;

  always_comb begin
    hdrIn = '0;
    payIn = '0;
    if (strb.syncPush) begin
      hdrIn = {PK_SYNC, 5'(LEN_SYNC)};
      payIn = PAY_W'(nextAddr);
    end else if (strb.trapPush) begin
      hdrIn = {PK_TRAP, 5'(LEN_TRAP)};
      payIn = PAY_W'({nextAddr, retireAddr, causeByte, mapBytes, cntByte});
    end else if (strb.addrPush) begin
      hdrIn = {PK_ADDR, 5'(LEN_ADDR)};
      payIn = PAY_W'({deltaAddr, mapBytes, cntByte});
    end else if (strb.mapPush) begin
      hdrIn = {PK_BRANCH, 5'(LEN_MAP)};
      payIn = PAY_W'({mapBytes, cntByte});
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapReg   <= '0;
      mapCnt   <= '0;
      lastAddr <= '0;
    end else begin
      if (strb.mapClear || anyPush) begin
        mapReg <= '0;
        mapCnt <= '0;
      end else if (strb.bitShift) begin
        mapReg <= mapNow;
        mapCnt <= cntNow;
      end
      if (anyPush && !strb.mapPush) lastAddr <= nextAddr;
    end
  end

  // packet FIFO
  logic [7:0]       hdrMem [FIFO_DEPTH];
  logic [PAY_W-1:0] payMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [OCC_W-1:0] occ;
  logic [4:0]       byteIdx, curLen;
  logic [7:0]       curHdr, shiftAmt;
  logic [PAY_W-1:0] curPay;
  logic             pop;

  assign fifoFull = (occ == OCC_W'(FIFO_DEPTH));
  assign outValid = (occ != '0);
  assign curHdr   = hdrMem[rdPtr];
  assign curPay   = payMem[rdPtr];
  assign curLen   = curHdr[4:0];
  assign shiftAmt = {byteIdx - 5'd1, 3'b000};
  assign outData  = (byteIdx == 5'd0) ? curHdr : 8'(curPay >> shiftAmt);
  assign pop      = outValid && outReady && (byteIdx == curLen);

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (anyPush) begin
      hdrMem[wrPtr] <= hdrIn;
      payMem[wrPtr] <= payIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      occ     <= '0;
      byteIdx <= '0;
    end else begin
      if (anyPush) wrPtr <= ptrInc(wrPtr);
      if (pop) begin
        rdPtr   <= ptrInc(rdPtr);
        byteIdx <= '0;
      end else if (outValid && outReady) begin
        byteIdx <= byteIdx + 5'd1;
      end
      occ <= occ + OCC_W'(anyPush) - OCC_W'(pop);
    end
  end

  // R9
  push_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyPush |-> !fifoFull);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R7
  map_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapCnt < CNT_W'(MAP_W));

  // R3
  bit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bitShift && !anyPush && !strb.mapClear) |=> (mapCnt == $past(mapCnt) + CNT_W'(1)));

endmodule

// File: rtl/branchTraceEncoder.sv
module branchTraceEncoder
  import trace_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAP_W      = 31,
  parameter int CAUSE_W    = 7,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               traceEnable,
  input  logic               retireValid,
  input  logic [2:0]         retireType,
  input  logic [ADDR_W-1:0]  retireAddr,
  input  logic [ADDR_W-1:0]  nextAddr,
  input  logic [CAUSE_W-1:0] trapCause,
  output logic               outValid,
  output logic [7:0]         outData,
  input  logic               outReady,
  output logic               overflow
);

  strobes_t strb;
  logic     mapLastSlot, fifoFull;

  traceCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .traceEnable (traceEnable),
    .retireValid (retireValid),
    .retireType  (retireType),
    .mapLastSlot (mapLastSlot),
    .fifoFull    (fifoFull),
    .strb        (strb),
    .overflow    (overflow)
  );

  traceDatapath #(
    .ADDR_W     (ADDR_W),
    .MAP_W      (MAP_W),
    .CAUSE_W    (CAUSE_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .retireType  (retireType),
    .retireAddr  (retireAddr),
    .nextAddr    (nextAddr),
    .trapCause   (trapCause),
    .mapLastSlot (mapLastSlot),
    .fifoFull    (fifoFull),
    .outValid    (outValid),
    .outData     (outData),
    .outReady    (outReady)
  );

endmodule

// File: tb/branchTraceEncoder_test.sv
module branchTraceEncoder_test;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        traceEnable = 1'b0;
  logic        retireValid = 1'b0;
  logic [2:0]  retireType = '0;
  logic [31:0] retireAddr = '0;
  logic [31:0] nextAddr = '0;
  logic [6:0]  trapCause = '0;
  logic        outValid;
  logic [7:0]  outData;
  logic        outReady = 1'b1;
  logic        overflow;

  int checks = 0;
  int errors = 0;

  typedef struct {logic [7:0] b; int rq;} exp_t;
  exp_t expQ[$];
  int   lenQ[$];
  int   pushedPkts = 0;
  int   donePkts = 0;
  int   bytesIn = 0;
  bit   stall = 1'b0;
  bit   jitter = 1'b0;
  int   cyc = 0;

  // bench model state
  bit          mSync = 1'b1;
  bit          mOvf = 1'b0;
  int          mCnt = 0;
  logic [31:0] mMap = '0;
  logic [31:0] mLast = '0;

  branchTraceEncoder uut (
    .clk(clk), .rstN(rstN), .traceEnable(traceEnable), .retireValid(retireValid),
    .retireType(retireType), .retireAddr(retireAddr), .nextAddr(nextAddr),
    .trapCause(trapCause), .outValid(outValid), .outData(outData),
    .outReady(outReady), .overflow(overflow)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 outReady = stall ? 1'b0 : (jitter ? cyc[0] : 1'b1);
  end

  // monitor
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected byte: actual %02h expected none", outData);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (outData !== e.b) begin
          errors++;
          $display("FAIL R%0d byte: actual %02h expected %02h", e.rq, outData, e.b);
        end
        bytesIn++;
        if (lenQ.size() > 0 && bytesIn == lenQ[0]) begin
          void'(lenQ.pop_front());
          bytesIn = 0;
          donePkts++;
        end
      end
    end
  end

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic pushVal(input logic [31:0] v, input int n, input int rq);
    for (int i = 0; i < n; i++) expQ.push_back('{b: v[i*8 +: 8], rq: rq});
  endtask

  task automatic setEnable(input bit en);
    traceEnable = en;
    if (!en) begin mSync = 1'b1; mCnt = 0; mMap = '0; end
    @(posedge clk); #1;
  endtask

  // driver + expected-packet model
  task automatic ret(input logic [2:0] t, input logic [31:0] a, input logic [31:0] n,
                     input logic [6:0] c, input int rq);
    int kind;
    kind = 0;
    if (traceEnable) begin
      if (mSync) kind = 1;
      else if (t == 3'd1 || t == 3'd2) begin
        mMap[mCnt] = (t == 3'd2);
        mCnt++;
        if (mCnt == 31) kind = 2;
      end else if (t == 3'd4) kind = 3;
      else if (t == 3'd5 || t == 3'd6) kind = 4;
      if (kind != 0) begin
        if (pushedPkts - donePkts == DEPTH) begin
          mOvf = 1'b1; mSync = 1'b1; mCnt = 0; mMap = '0;
        end else begin
          pushedPkts++;
          case (kind)
            1: begin pushVal(32'h24, 1, rq); pushVal(n, 4, rq); lenQ.push_back(5); end
            2: begin pushVal(32'h45, 1, rq); pushVal(mCnt, 1, rq); pushVal(mMap, 4, rq); lenQ.push_back(6); end
            3: begin pushVal(32'h69, 1, rq); pushVal(mCnt, 1, rq); pushVal(mMap, 4, rq);
                     pushVal(n - mLast, 4, rq); lenQ.push_back(10); end
            default: begin pushVal(32'h8E, 1, rq); pushVal(mCnt, 1, rq); pushVal(mMap, 4, rq);
                     pushVal({24'h0, (t == 3'd6), c}, 1, rq); pushVal(a, 4, rq); pushVal(n, 4, rq);
                     lenQ.push_back(15); end
          endcase
          if (kind == 1) begin mSync = 1'b0; mOvf = 1'b0; end
          else begin mCnt = 0; mMap = '0; end
          if (kind != 2) mLast = n;
        end
      end
    end
    retireType = t; retireAddr = a; nextAddr = n; trapCause = c; retireValid = 1'b1;
    @(posedge clk); #1;
    retireValid = 1'b0;
    check(overflow === mOvf, 9, "overflow flag", overflow, mOvf);
  endtask

  task automatic drain();
    int w;
    w = 0;
    while ((expQ.size() != 0 || outValid) && w < 2000) begin @(posedge clk); #1; w++; end
    check(expQ.size() == 0, 8, "pending expected bytes", expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pc;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, 8, "reset outValid", outValid, 0);
    check(overflow === 1'b0, 9, "reset overflow", overflow, 0);

    // R10 retirements while disabled produce nothing
    ret(3'd4, 32'h40, 32'h900, 7'd0, 10);
    ret(3'd5, 32'h44, 32'h100, 7'd1, 10);
    setEnable(1'b1);

    // R1 sync on first enabled retirement; branch on this cycle records no bit
    ret(3'd2, 32'h1000, 32'h1234_5678, 7'd0, 1);
    // R2 sequential and R4 direct jumps are silent
    ret(3'd0, 32'h1234_5678, 32'h1234_567C, 7'd0, 2);
    ret(3'd3, 32'h1234_567C, 32'h1234_6000, 7'd0, 4);
    ret(3'd0, 32'h1234_6000, 32'h1234_6004, 7'd0, 2);
    repeat (12) @(posedge clk);
    #1 drain();
    @(negedge clk);
    check(outValid === 1'b0, 2, "silent after seq/direct", outValid, 0);

    // R3 + R5: branches then indirect jump with negative delta
    ret(3'd2, 32'h1234_6004, 32'h1234_7000, 7'd0, 3);
    ret(3'd1, 32'h1234_7000, 32'h1234_7004, 7'd0, 3);
    ret(3'd3, 32'h1234_7004, 32'h1234_8000, 7'd0, 4);
    ret(3'd2, 32'h1234_8000, 32'h1234_8100, 7'd0, 3);
    ret(3'd4, 32'h1234_8100, 32'h1234_0010, 7'd0, 5);
    // R5 positive delta, empty history
    ret(3'd4, 32'h1234_0010, 32'h2000_0000, 7'd0, 5);

    // R6 exception then interrupt with pending bits
    ret(3'd1, 32'h2000_0000, 32'h2000_0004, 7'd0, 3);
    ret(3'd5, 32'h2000_0004, 32'h0000_0100, 7'd13, 6);
    ret(3'd2, 32'h0000_0100, 32'h0000_0200, 7'd0, 3);
    ret(3'd6, 32'h0000_0200, 32'h0000_0180, 7'd7, 6);
    ret(3'd4, 32'h0000_0204, 32'h0000_0300, 7'd0, 5);
    drain();

    // R7 automatic flush at 31 branches, R8 with a jittering consumer
    jitter = 1'b1;
    pc = 32'h3000;
    for (int i = 0; i < 33; i++) begin
      ret(((i % 3) == 1) ? 3'd1 : 3'd2, pc, pc + 32'h40, 7'd0, 7);
      pc = pc + 32'h40;
    end
    ret(3'd4, pc, 32'h5000, 7'd0, 5);
    drain();
    jitter = 1'b0;

    // R9 overflow under stall, then resync
    stall = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) ret(3'd4, 32'h6000 + i*8, 32'h7000 + i*16, 7'd0, 9);
    ret(3'd2, 32'h7100, 32'h7200, 7'd0, 9);
    ret(3'd0, 32'h7200, 32'h7204, 7'd0, 9);
    check(overflow === 1'b1, 9, "overflow held under stall", overflow, 1);
    stall = 1'b0;
    drain();
    ret(3'd0, 32'h7204, 32'h7208, 7'd0, 9);
    check(overflow === 1'b0, 9, "overflow cleared by sync", overflow, 0);
    ret(3'd4, 32'h7208, 32'h7000, 7'd0, 9);
    drain();

    // R10 disable then re-enable resyncs and drops history
    ret(3'd2, 32'h7000, 32'h7010, 7'd0, 10);
    setEnable(1'b0);
    ret(3'd4, 32'h7010, 32'h8000, 7'd0, 10);
    ret(3'd6, 32'h8000, 32'h0100, 7'd2, 10);
    repeat (10) @(posedge clk);
    #1 check(expQ.size() == 0, 10, "nothing while disabled", expQ.size(), 0);
    setEnable(1'b1);
    ret(3'd0, 32'h8100, 32'h8104, 7'd0, 10);
    ret(3'd4, 32'h8104, 32'h8200, 7'd0, 10);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule